// File: doc/BRIEF.md
# Fallback-Slot Round-Robin Memory Arbiter

This block shares one memory port among sixteen cores using a fixed time-slot rotation. A slot counter steps through the cores one per clock. Each core owns exactly one slot in every sixteen cycles. A core that asks for memory when its own slot comes round always gets that slot. Its access timing is therefore the same as in a plain rotation.

Core 0 is special. It keeps its own slot like any other core. It also picks up any slot whose owner is not asking for memory, as long as core 0 itself is asking. A slot that neither its owner nor core 0 wants stays idle. No table or setup is needed, and the timing seen by cores 1 to 15 is unaffected.

Each core presents a request with an address, write data, a write flag and a transfer size. The winning core's fields are placed on the memory port in the same cycle as its grant. The memory is synchronous. The read data it returns is flagged to the reading core one cycle after the grant.

Top module: `fallback_slot_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it with no request, no grant is given, the memory enable is low and no read-valid bit is set. The slot counter restarts at slot 0 in the first cycle after reset.
- R2: The slot counter advances by one every clock whether or not the slot is used, wrapping from slot 15 to slot 0. A core other than 0 that requests without pause is granted once in every 16 cycles.
- R3: When the core that owns the current slot is requesting, that core receives the grant.
- R4: When the owner of the current slot is not requesting and core 0 is requesting, core 0 receives the grant.
- R5: Core 0 receives the grant in slot 0 whenever it requests. When core 0 alone requests without pause, it is granted every cycle.
- R6: When neither the slot owner nor core 0 is requesting, no grant is given and the memory enable stays low.
- R7: The grant vector (bit k for core k) has at most one bit set, and only for a core that is requesting in that cycle.
- R8: In a granted cycle, the memory port carries the winner's address, write data, write flag and size. The memory enable is high in that same cycle.
- R9: A granted read sets the winner's read-valid bit in the next cycle, with the memory's returned word on the read-data output. A granted write sets no read-valid bit.
- R10: Over 64 cycles in which core 0 and cores 3 and 9 request without pause and no other core requests, cores 3 and 9 are each granted 4 times and core 0 is granted 56 times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqVec | input | 16 | Request bit per core |
| reqAddr | input | 16*ADDR_W | Per-core address, core k in bits k*ADDR_W upward |
| reqWdata | input | 16*DATA_W | Per-core write data |
| reqWe | input | 16 | Per-core write flag (1 write, 0 read) |
| reqSize | input | 16*SIZE_W | Per-core transfer size code |
| grantVec | output | 16 | One-hot grant to the winning core |
| rdValid | output | 16 | Read-data valid, one cycle after a read grant |
| rdData | output | DATA_W | Read data returned from memory |
| memEn | output | 1 | Memory access enable |
| memWe | output | 1 | Memory write enable |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | DATA_W | Memory write data |
| memSize | output | SIZE_W | Memory transfer size |
| memRdata | input | DATA_W | Synchronous read data from memory |

## Verification
The hardest situation to create from the ports is core 0 picking up a slot while the slot's owner is idle, mixed with owners that do request in the very next slots. Only there do the own-slot rule and the fallback rule decide between the same two cores. The stimulus tracks the slot number by counting clocks from reset release. It then holds fixed request masks across whole rotations, followed by hundreds of cycles of pseudo-random masks in which core 0 requests often and the others sparsely. This produces runs of owner wins, fallback wins and idle slots next to each other, with reads and writes to a small address range so that reads return recently written words.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int CORES = 16;
  localparam int IDX_W = $clog2(CORES);

  typedef struct packed {
    logic             fire;
    logic [IDX_W-1:0] winIdx;
  } arbStrobe_t;
endpackage

// File: rtl/arb_slot_ctrl.sv
module arb_slot_ctrl
  import arb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CORES-1:0] reqVec,
  output logic [IDX_W-1:0] slotPtr,
  output logic [CORES-1:0] grantVec,
  output arbStrobe_t       strobe
);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(CORES - 1);
  localparam int FALLBACK = 0;

  always_ff @(posedge clk) begin
    if (!rstN) slotPtr <= '0;
    else if (slotPtr == LAST_SLOT) slotPtr <= '0;
    else slotPtr <= slotPtr + 1'b1;
  end

  logic ownerReq;
  assign ownerReq = reqVec[slotPtr];

  always_comb begin
    strobe = '0;
    if (ownerReq) begin
      strobe.fire   = 1'b1;
      strobe.winIdx = slotPtr;
    end else if (reqVec[FALLBACK]) begin
      strobe.fire   = 1'b1;
      strobe.winIdx = IDX_W'(FALLBACK);
    end
  end

  for (genvar g = 0; g < CORES; g++) begin : gGrant
    assign grantVec[g] = strobe.fire && (strobe.winIdx == IDX_W'(g));
  end
endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  arbStrobe_t              strobe,
  input  logic [CORES-1:0]        grantVec,
  input  logic [CORES*ADDR_W-1:0] reqAddr,
  input  logic [CORES*DATA_W-1:0] reqWdata,
  input  logic [CORES-1:0]        reqWe,
  input  logic [CORES*SIZE_W-1:0] reqSize,
  output logic                    memEn,
  output logic                    memWe,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [DATA_W-1:0]       memWdata,
  output logic [SIZE_W-1:0]       memSize,
  input  logic [DATA_W-1:0]       memRdata,
  output logic [CORES-1:0]        rdValid,
  output logic [DATA_W-1:0]       rdData
);
  logic winWe;

  always_comb begin
    winWe    = reqWe[strobe.winIdx];
    memEn    = strobe.fire;
    memWe    = strobe.fire && winWe;
    memAddr  = reqAddr[strobe.winIdx*ADDR_W +: ADDR_W];
    memWdata = reqWdata[strobe.winIdx*DATA_W +: DATA_W];
    memSize  = reqSize[strobe.winIdx*SIZE_W +: SIZE_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValid <= '0;
    else if (strobe.fire && !winWe) rdValid <= grantVec;
    else rdValid <= '0;
  end

  assign rdData = memRdata;
endmodule

// File: rtl/fallback_slot_arbiter.sv
module fallback_slot_arbiter
  import arb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [CORES-1:0]        reqVec,
  input  logic [CORES*ADDR_W-1:0] reqAddr,
  input  logic [CORES*DATA_W-1:0] reqWdata,
  input  logic [CORES-1:0]        reqWe,
  input  logic [CORES*SIZE_W-1:0] reqSize,
  output logic [CORES-1:0]        grantVec,
  output logic [CORES-1:0]        rdValid,
  output logic [DATA_W-1:0]       rdData,
  output logic                    memEn,
  output logic                    memWe,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [DATA_W-1:0]       memWdata,
  output logic [SIZE_W-1:0]       memSize,
  input  logic [DATA_W-1:0]       memRdata
);
  logic [IDX_W-1:0] slotPtr;
  arbStrobe_t       strobe;

  arb_slot_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqVec   (reqVec),
    .slotPtr  (slotPtr),
    .grantVec (grantVec),
    .strobe   (strobe)
  );

  arb_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SIZE_W (SIZE_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .grantVec (grantVec),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqWe    (reqWe),
    .reqSize  (reqSize),
    .memEn    (memEn),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memSize  (memSize),
    .memRdata (memRdata),
    .rdValid  (rdValid),
    .rdData   (rdData)
  );
endmodule

// File: rtl/arb_checker.sv
module arb_checker
  import arb_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [CORES-1:0] reqVec,
  input logic [CORES-1:0] grantVec,
  input logic [CORES-1:0] rdValid,
  input logic             memEn,
  input logic             memWe,
  input logic [IDX_W-1:0] slotPtr
);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(CORES - 1);

  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (slotPtr == (($past(slotPtr) == LAST_SLOT) ? IDX_W'(0) : IDX_W'($past(slotPtr) + 1'b1))));

  // R3
  owner_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqVec[slotPtr] |-> grantVec[slotPtr]);

  // R4
  fallback_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!reqVec[slotPtr] && reqVec[0]) |-> grantVec[0]);

  // R6
  idle_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!reqVec[slotPtr] && !reqVec[0]) |-> (grantVec == '0 && !memEn));

  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec) && ((grantVec & ~reqVec) == '0));

  // R9
  read_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && !memWe) |=> (rdValid == $past(grantVec)));

  // R9
  write_no_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memWe) |=> (rdValid == '0));
endmodule

bind fallback_slot_arbiter arb_checker chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .reqVec   (reqVec),
  .grantVec (grantVec),
  .rdValid  (rdValid),
  .memEn    (memEn),
  .memWe    (memWe),
  .slotPtr  (slotPtr)
);

// File: tb/fallback_slot_arbiter_tb_top.sv
`timescale 1ns/1ps
module fallback_slot_arbiter_tb_top;
  import arb_pkg::*;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int SIZE_W = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                    rstN;
  logic [CORES-1:0]        reqVec;
  logic [CORES*ADDR_W-1:0] reqAddr;
  logic [CORES*DATA_W-1:0] reqWdata;
  logic [CORES-1:0]        reqWe;
  logic [CORES*SIZE_W-1:0] reqSize;
  logic [CORES-1:0]        grantVec, rdValid;
  logic [DATA_W-1:0]       rdData, memWdata, memRdata;
  logic                    memEn, memWe;
  logic [ADDR_W-1:0]       memAddr;
  logic [SIZE_W-1:0]       memSize;

  fallback_slot_arbiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqWe(reqWe), .reqSize(reqSize), .grantVec(grantVec), .rdValid(rdValid),
    .rdData(rdData), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memSize(memSize), .memRdata(memRdata)
  );

  // synchronous RAM model
  logic [DATA_W-1:0] ram [256];
  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) ram[memAddr[7:0]] <= memWdata;
      else memRdata <= ram[memAddr[7:0]];
    end
  end

  typedef struct {
    logic [CORES-1:0]  vld;
    logic [DATA_W-1:0] data;
  } rdExp_t;

  rdExp_t            rdQ[$];
  logic [DATA_W-1:0] shadow [256];
  int checks = 0, errors = 0, slotM = 0;
  int grantCnt [CORES];
  bit finished = 0;

  logic [CORES-1:0]  curReq, curWe;
  logic [ADDR_W-1:0] curAddr [CORES];
  logic [DATA_W-1:0] curWdata [CORES];
  logic [SIZE_W-1:0] curSize [CORES];
  logic [31:0]       lfsr = 32'hACE1_2345;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic stepLfsr();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  task automatic clearStim();
    curReq = '0; curWe = '0;
    for (int k = 0; k < CORES; k++) begin
      curAddr[k] = ADDR_W'(k); curWdata[k] = DATA_W'(32'h1000 + k); curSize[k] = '0;
    end
  endtask

  // driver plus scoreboard monitor, one clock per call
  task automatic stepCycle();
    rdExp_t e;
    int win;
    string tag;
    logic [CORES-1:0] expG;
    @(negedge clk);
    e = rdQ.pop_front();
    chk(rdValid == e.vld, "R9", "rdValid", rdValid, e.vld);
    if (e.vld != '0) chk(rdData == e.data, "R9", "rdData", rdData, e.data);
    reqVec = curReq; reqWe = curWe;
    for (int k = 0; k < CORES; k++) begin
      reqAddr[k*ADDR_W +: ADDR_W]  = curAddr[k];
      reqWdata[k*DATA_W +: DATA_W] = curWdata[k];
      reqSize[k*SIZE_W +: SIZE_W]  = curSize[k];
    end
    #1;
    if (curReq[slotM]) begin win = slotM; tag = (slotM == 0) ? "R5" : "R3"; end
    else if (curReq[0]) begin win = 0; tag = "R4"; end
    else begin win = -1; tag = "R6"; end
    expG = (win >= 0) ? (CORES'(1) << win) : '0;
    chk(grantVec == expG, tag, "grantVec", grantVec, expG);
    chk(memEn == (win >= 0), tag, "memEn", memEn, win >= 0);
    e.vld = '0; e.data = '0;
    if (win >= 0) begin
      chk(memAddr == curAddr[win], "R8", "memAddr", memAddr, curAddr[win]);
      chk(memWe == curWe[win], "R8", "memWe", memWe, curWe[win]);
      chk(memSize == curSize[win], "R8", "memSize", memSize, curSize[win]);
      if (curWe[win]) begin
        chk(memWdata == curWdata[win], "R8", "memWdata", memWdata, curWdata[win]);
        shadow[curAddr[win][7:0]] = curWdata[win];
      end else begin
        e.vld = expG; e.data = shadow[curAddr[win][7:0]];
      end
    end
    rdQ.push_back(e);
    for (int k = 0; k < CORES; k++) if (grantVec[k]) grantCnt[k]++;
    @(posedge clk);
    slotM = (slotM + 1) % CORES;
  endtask

  task automatic clearCounts();
    for (int k = 0; k < CORES; k++) grantCnt[k] = 0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4ns * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    rdQ.push_back('{vld: '0, data: '0});
    for (int a = 0; a < 256; a++) begin ram[a] = '0; shadow[a] = '0; end
    clearStim();
    rstN = 1'b0; reqVec = '0; reqWe = '0; reqAddr = '0; reqWdata = '0; reqSize = '0;
    repeat (5) @(posedge clk);
    #1;
    chk(grantVec == '0 && !memEn && rdValid == '0, "R1", "outputs in reset",
        {grantVec, memEn}, 0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(grantVec == '0, "R1", "grant after reset", grantVec, 0);
    chk(!memEn && rdValid == '0, "R1", "mem/rdValid after reset", {memEn, rdValid}, 0);
    @(posedge clk);
    slotM = 1;

    // idle slots
    repeat (20) stepCycle();

    // core 7 alone: its own slot only, once per rotation (R1 alignment, R2 wrap)
    clearStim(); curReq[7] = 1'b1; clearCounts();
    repeat (48) stepCycle();
    chk(grantCnt[7] == 3, "R2", "core7 grants in 48 cycles", grantCnt[7], 3);

    // core 0 alone: every cycle
    clearStim(); curReq[0] = 1'b1; clearCounts();
    repeat (32) stepCycle();
    chk(grantCnt[0] == 32, "R5", "core0 grants alone", grantCnt[0], 32);

    // all cores: strict rotation
    clearStim(); curReq = '1; clearCounts();
    repeat (32) stepCycle();
    for (int k = 0; k < CORES; k++)
      chk(grantCnt[k] == 2, "R3", "per-core grants all busy", grantCnt[k], 2);

    // core 15 and core 1 around the wrap, no fallback
    clearStim(); curReq[15] = 1'b1; curReq[1] = 1'b1; clearCounts();
    repeat (32) stepCycle();
    chk(grantCnt[15] == 2 && grantCnt[1] == 2, "R2", "wrap grants 15/1",
        {grantCnt[15], grantCnt[1]}, {32'd2, 32'd2});

    // fallback share
    clearStim(); curReq[0] = 1'b1; curReq[3] = 1'b1; curReq[9] = 1'b1; clearCounts();
    repeat (64) stepCycle();
    chk(grantCnt[3] == 4, "R10", "core3 count", grantCnt[3], 4);
    chk(grantCnt[9] == 4, "R10", "core9 count", grantCnt[9], 4);
    chk(grantCnt[0] == 56, "R10", "core0 count", grantCnt[0], 56);

    // pseudo-random traffic with reads and writes
    for (int n = 0; n < 600; n++) begin
      for (int k = 0; k < CORES; k++) begin
        stepLfsr();
        curReq[k]   = (k == 0) ? (lfsr[0] | lfsr[2]) : (lfsr[0] & lfsr[3]);
        curWe[k]    = lfsr[5];
        curSize[k]  = lfsr[7:6];
        curAddr[k]  = ADDR_W'(lfsr[11:8]);
        curWdata[k] = lfsr ^ 32'h5A5A_0000;
      end
      stepCycle();
    end

    // drain last read
    clearStim();
    stepCycle();
    // R7 one-hot grants are checked against exact expected vectors in every cycle
    finish();
  end
endmodule